// File: doc/BRIEF.md
# Faster-Clock Detector

This block decides, after a master reset, which of two free-running clocks runs faster: the clock of the write side or the clock of the read side. A counter in each clock domain starts from zero when reset releases and counts edges of its own clock up to a fixed terminal count, then stops there. Each counter's terminal flag is carried into a common reference clock domain through a short synchronizer chain. The first flag to arrive decides the result.

The result is one select bit, `wr_faster`. A value of 1 means the write clock is faster and 0 means the read clock is faster. A `done` output rises once a decision is held. Logic in the reference domain can write the select bit at any time. If that write comes before the race ends, it also ends the measurement, and a counter that finishes later cannot change the bit. The two clocks are expected to stay within a factor of two of each other in frequency.

Top module: `clk_race_detect`

## Requirements
- R1: While reset is asserted and after its release, before any decision or override, `wr_faster` is 0 and `done` is 0.
- R2: Each counter is `CNT_W` (9) bits wide and starts from zero at reset release. It counts rising edges of its own clock up to `TERM_CNT` (256) and then holds that value.
- R3: If the write clock is faster, `wr_faster` becomes 1 with `done`. If the read clock is faster, it becomes 0 with `done`.
- R4: If both terminal flags reach the reference domain on the same reference edge, the result is 1 (write clock declared faster).
- R5: Once `done` is 1 it stays 1 until the next reset. Without an override, `wr_faster` does not change after the decision.
- R6: A reference-clock edge with `ovr_we` = 1 loads `ovr_val` into `wr_faster` and sets `done`. Both outputs are visible after that edge.
- R7: An override written before the decision cancels the measurement. Counters that finish later do not change `wr_faster`.
- R8: `done` does not rise before `TERM_CNT - 1` periods of the faster clock after reset release. It does rise within `TERM_CNT + 1` such periods plus four reference periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for synchronizers, decision and override |
| wr_clk | input | 1 | Write-side clock under measurement |
| rd_clk | input | 1 | Read-side clock under measurement |
| rst_n | input | 1 | Active-low master reset, asynchronous assertion |
| ovr_we | input | 1 | Override write strobe (reference domain) |
| ovr_val | input | 1 | Value written to the select bit on override |
| wr_faster | output | 1 | 1: write clock faster, 0: read clock faster |
| done | output | 1 | A decision or an override is held |

## Verification
On every cycle, the assertions check four things: that each counter stops at its terminal value and stays there, that `done` never falls once set, that the select bit holds steady after a decision unless an override arrives, and that an override lands on the very next reference edge. A rising `done` without an override is also checked to have a counter at its terminal value behind it. Three behaviours can only be shown by the bench's scenarios, because each depends on the relation between two clock frequencies: which clock wins the race, the tie-break when both clocks share a period and phase, and the window in time where `done` may rise. The bench also covers the race that an early override cancels.

// File: rtl/clk_race_detect.sv
module clk_race_detect #(
  parameter int CNT_W    = 9,
  parameter int TERM_CNT = 256,
  parameter int SYNC_LEN = 2
) (
  input  logic ref_clk,
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic ovr_we,
  input  logic ovr_val,
  output logic wr_faster,
  output logic done
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TERM_CNT);

  logic [CNT_W-1:0]    wr_cnt, rd_cnt;
  logic [SYNC_LEN-1:0] wr_sync, rd_sync;
  logic                wr_tc, rd_tc, wr_arr, rd_arr;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n)            wr_cnt <= '0;
    else if (wr_cnt != TERM) wr_cnt <= wr_cnt + 1'b1;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n)            rd_cnt <= '0;
    else if (rd_cnt != TERM) rd_cnt <= rd_cnt + 1'b1;

  assign wr_tc = (wr_cnt == TERM);
  assign rd_tc = (rd_cnt == TERM);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      wr_sync <= '0;
      rd_sync <= '0;
    end else begin
      wr_sync <= {wr_sync[SYNC_LEN-2:0], wr_tc};
      rd_sync <= {rd_sync[SYNC_LEN-2:0], rd_tc};
    end

  assign wr_arr = wr_sync[SYNC_LEN-1];
  assign rd_arr = rd_sync[SYNC_LEN-1];

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      wr_faster <= 1'b0;
      done      <= 1'b0;
    end else if (ovr_we) begin
      wr_faster <= ovr_val;
      done      <= 1'b1;
    end else if (!done && (wr_arr || rd_arr)) begin
      wr_faster <= wr_arr;
      done      <= 1'b1;
    end
endmodule

// File: rtl/clk_race_detect_chk.sv
module clk_race_detect_chk #(
  parameter int CNT_W    = 9,
  parameter int TERM_CNT = 256
) (
  input logic             ref_clk,
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst_n,
  input logic             ovr_we,
  input logic             ovr_val,
  input logic             wr_faster,
  input logic             done,
  input logic [CNT_W-1:0] wr_cnt,
  input logic [CNT_W-1:0] rd_cnt
);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TERM_CNT);

  always @(posedge ref_clk)
    if (rst_n === 1'b0)
      p_reset_clear_r1: assert (!done && !wr_faster);

  p_wr_cnt_cap_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_cnt <= TERM);
  p_wr_cnt_hold_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_cnt == TERM |=> wr_cnt == TERM);
  p_rd_cnt_cap_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_cnt <= TERM);
  p_rd_cnt_hold_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_cnt == TERM |=> rd_cnt == TERM);

  p_done_needs_tc_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(done) && !$past(ovr_we) |-> (wr_cnt == TERM || rd_cnt == TERM));

  p_done_sticky_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    done |=> done);
  p_sel_hold_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    done && !ovr_we |=> $stable(wr_faster));

  p_ovr_apply_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ovr_we |=> done && (wr_faster == $past(ovr_val)));
endmodule

bind clk_race_detect clk_race_detect_chk #(.CNT_W(CNT_W), .TERM_CNT(TERM_CNT)) u_chk (
  .ref_clk(ref_clk), .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .ovr_we(ovr_we), .ovr_val(ovr_val), .wr_faster(wr_faster), .done(done),
  .wr_cnt(wr_cnt), .rd_cnt(rd_cnt)
);

// File: tb/clk_race_detect_tb.sv
`timescale 1ns/1ps
module clk_race_detect_tb;
  localparam int REF_PERIOD = 4;
  localparam int TERM       = 256;

  logic ref_clk = 0, wr_clk = 0, rd_clk = 0;
  logic rst_n = 0, ovr_we = 0, ovr_val = 0;
  logic wr_faster, done;
  logic clk_run = 0;
  int   wr_half = 5, rd_half = 5;
  int   total = 0, bad = 0;

  clk_race_detect u_dut (
    .ref_clk(ref_clk), .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .ovr_we(ovr_we), .ovr_val(ovr_val), .wr_faster(wr_faster), .done(done)
  );

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  always begin
    wr_clk = 0;
    wait (clk_run);
    while (clk_run) begin #(wr_half) wr_clk = 1; #(wr_half) wr_clk = 0; end
  end

  always begin
    rd_clk = 0;
    wait (clk_run);
    while (clk_run) begin #(rd_half) rd_clk = 1; #(rd_half) rd_clk = 0; end
  end

  function automatic bit exp_winner(int wh, int rh);
    return (wh <= rh);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(int wh, int rh);
    rst_n   = 0;
    clk_run = 0;
    #200;
    wr_half = wh;
    rd_half = rh;
    clk_run = 1;
    repeat (3) @(negedge ref_clk);
    check("R1 sel in reset", wr_faster, 0);
    check("R1 done in reset", done, 0);
    @(negedge ref_clk);
    #0.5 rst_n = 1;
  endtask

  task automatic race(int wh, int rh, string tag);
    realtime t0, t_done, lo, hi;
    int fast;
    bit seen;
    restart(wh, rh);
    t0   = $realtime;
    fast = (wh < rh) ? wh : rh;
    lo   = t0 + real'((TERM - 1) * 2 * fast);
    hi   = t0 + real'((TERM + 1) * 2 * fast + 4 * REF_PERIOD);
    seen = 0;
    @(negedge ref_clk);
    check({"R1 idle after release ", tag}, done, 0);
    while (!seen && $realtime < hi + 100) begin
      @(negedge ref_clk);
      if (done) begin seen = 1; t_done = $realtime; end
    end
    check({"R8 done rises ", tag}, seen, 1);
    if (seen) begin
      check({"R8 not early ", tag}, t_done >= lo, 1);
      check({"R8 not late ", tag}, t_done <= hi, 1);
      check({"R3 winner ", tag}, wr_faster, exp_winner(wh, rh));
    end
    repeat (TERM * rh / REF_PERIOD + 20) @(negedge ref_clk);
    check({"R5 done holds ", tag}, done, 1);
    check({"R5 sel holds ", tag}, wr_faster, exp_winner(wh, rh));
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 31;
    void'($urandom(seed));

    race(4, 8, "write 2x");
    race(8, 4, "read 2x");
    race(6, 6, "tie R4");

    for (int i = 0; i < 6; i++) begin
      int f, s;
      f = 4 + int'($urandom % 4);
      s = f + (f + 3) / 4 + int'($urandom % (f - (f + 3) / 4 + 1));
      if ($urandom % 2) race(f, s, "rand wr");
      else              race(s, f, "rand rd");
    end

    // R6: override after a decision flips the bit
    @(negedge ref_clk);
    ovr_we = 1; ovr_val = ~wr_faster;
    begin
      logic want;
      want = ovr_val;
      @(negedge ref_clk);
      ovr_we = 0;
      check("R6 override applied", wr_faster, want);
      check("R6 done after override", done, 1);
      repeat (5) @(negedge ref_clk);
      check("R5 override value holds", wr_faster, want);
    end

    // R7: early override cancels the race (write clock faster, force 0)
    restart(4, 8);
    @(negedge ref_clk);
    ovr_we = 1; ovr_val = 0;
    @(negedge ref_clk);
    ovr_we = 0;
    check("R7 early override sel", wr_faster, 0);
    check("R7 early override done", done, 1);
    repeat (TERM * 16 / REF_PERIOD + 20) @(negedge ref_clk);
    check("R7 race cancelled", wr_faster, 0);

    // R7: read clock faster, force 1
    restart(8, 5);
    @(negedge ref_clk);
    ovr_we = 1; ovr_val = 1;
    @(negedge ref_clk);
    ovr_we = 0;
    repeat (TERM * 16 / REF_PERIOD + 20) @(negedge ref_clk);
    check("R7 race cancelled read", wr_faster, 1);
    check("R5 done sticky", done, 1);

    rst_n = 0;
    #20;
    check("R1 sel cleared by reset", wr_faster, 0);
    check("R1 done cleared by reset", done, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule